// File: doc/BRIEF.md
# Saturating Accumulator Shift Stage

This block sits in the feedback path of a 40-bit signed accumulator. Each cycle it takes the accumulator value and either passes it through unchanged or shifts it arithmetically by one to eight positions. Right shifts fill from the sign. Left shifts fill with zeros and can overflow. The result and a set of flag updates come out registered one cycle later.

For a left shift, the block reports whether any bit that leaves bit 39, or passes through it, disagrees with the original sign. When saturation is enabled, a left-shift result that does not fit the 32-bit signed range is clamped to the largest positive or largest negative 32-bit value, chosen by the original sign. The clamp also raises the limit update. The extension update tells the surrounding logic whether the stored result uses the eight guard bits above the 32-bit range. The sticky flag registers themselves are outside this block and take these update pulses.

Top module: `accsh_top`

## Requirements
- R1: While `rst_n` is low, `acc_out` is zero and `ext_upd`, `ovf_upd` and `lim_upd` are all 0.
- R2: With a shift count of 0, `acc_out` equals the input one cycle later and `ovf_upd` and `lim_upd` are 0, whatever `shl_sel` and `sat_en` are.
- R3: A shift count from 9 to 15 gives exactly the same outputs as a count of 8.
- R4: With `shl_sel`=0 (right) and count n, `acc_out` is the input shifted right by n, with bit 39 copied into the vacated upper n bits.
- R5: With `shl_sel`=1 (left) and saturation off, `acc_out` is the input shifted left by n, with zeros in the lower n bits and the upper bits discarded.
- R6: A right shift never sets `ovf_upd` or `lim_upd`.
- R7: A left shift by n sets `ovf_upd` exactly when any of input bits 39 down to 39−n differs from input bit 39.
- R8: With `sat_en`=1, a left shift with overflow, or whose shifted result bits 39..31 are not all equal, gives 0x00_7FFF_FFFF when input bit 39 is 0 and 0xFF_8000_0000 when it is 1, and sets `lim_upd`.
- R9: With `sat_en`=0, `lim_upd` is never set and no clamping happens.
- R10: `ext_upd` is 1 exactly when bits 39..31 of the output value are not all equal.
- R11: The outputs reflect the inputs sampled at the previous rising clock edge: one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_in | input | 40 | Accumulator value to shift |
| shl_sel | input | 1 | 1 = shift left, 0 = shift right |
| shift_cnt | input | 4 | Shift distance; 0 = pass through, above 8 acts as 8 |
| sat_en | input | 1 | Enables clamping of left shifts to the 32-bit range |
| acc_out | output | 40 | Shifted (and possibly clamped) value |
| ext_upd | output | 1 | Result uses the guard bits above the 32-bit range |
| ovf_upd | output | 1 | Set pulse for the sticky overflow flag |
| lim_upd | output | 1 | Set pulse for the sticky limit flag |

## Verification
The bench builds the block with its default parameters: a 40-bit accumulator, a 32-bit saturation range, a shift limit of 8 and a 4-bit count. With a 4-bit count, the values 9 through 15 can be driven, so the limiting of oversize counts is exercised. With an 8-position limit, overflow can come from guard-bit content alone or from bits that carry past the sign. This brings both kinds of clamp within reach, along with results that overflow the 32-bit range without overflowing 40 bits.

// File: rtl/accsh_pkg.sv
package accsh_pkg;

    localparam int ACC_W_DEF  = 40;
    localparam int SAT_W_DEF  = 32;
    localparam int MAX_SH_DEF = 8;
    localparam int CNT_W_DEF  = 4;

    typedef enum logic {
        DIR_RIGHT = 1'b0,
        DIR_LEFT  = 1'b1
    } shift_dir_e;

    typedef struct packed {
        logic ext;
        logic ovf;
        logic lim;
    } flag_upd_t;

endpackage

// File: rtl/accsh_count_limit.sv
module accsh_count_limit #(
    parameter int CNT_W  = 4,
    parameter int MAX_SH = 8,
    parameter int AMT_W  = $clog2(MAX_SH + 1)
) (
    input  logic [CNT_W-1:0] cnt_raw,
    output logic [AMT_W-1:0] amt
);

    localparam int SUM_W = (CNT_W > AMT_W) ? CNT_W : AMT_W;

    logic [SUM_W-1:0] cnt_wide;
    logic [SUM_W-1:0] lim_wide;

    always_comb begin
        cnt_wide = SUM_W'(cnt_raw);
        lim_wide = SUM_W'(MAX_SH);
        if (cnt_wide > lim_wide) begin
            amt = AMT_W'(MAX_SH);
        end else begin
            amt = AMT_W'(cnt_wide);
        end
    end

endmodule

// File: rtl/accsh_range.sv
module accsh_range #(
    parameter int ACC_W = 40,
    parameter int SAT_W = 32
) (
    input  logic [ACC_W-1:0] val,
    output logic             fits
);

    localparam int TOP_N = ACC_W - SAT_W + 1;

    logic [TOP_N-1:0] top_bits;

    always_comb begin
        top_bits = val[ACC_W-1:SAT_W-1];
        fits     = (top_bits == '0) || (top_bits == '1);
    end

endmodule

// File: rtl/accsh_left.sv
module accsh_left #(
    parameter int ACC_W  = 40,
    parameter int MAX_SH = 8,
    parameter int AMT_W  = $clog2(MAX_SH + 1)
) (
    input  logic [ACC_W-1:0] val,
    input  logic [AMT_W-1:0] amt,
    output logic [ACC_W-1:0] shifted,
    output logic             ovf
);

    logic [MAX_SH:0] ovf_by_amt;

    assign ovf_by_amt[0] = 1'b0;

    for (genvar k = 1; k <= MAX_SH; k++) begin : g_ovf
        logic [k:0] window;
        assign window        = val[ACC_W-1 -: k+1];
        assign ovf_by_amt[k] = |(window ^ {(k+1){val[ACC_W-1]}});
    end

    always_comb begin
        shifted = val << amt;
        ovf     = 1'b0;
        for (int k = 1; k <= MAX_SH; k++) begin
            if (amt == AMT_W'(k)) begin
                ovf = ovf_by_amt[k];
            end
        end
    end

endmodule

// File: rtl/accsh_top.sv
module accsh_top
    import accsh_pkg::*;
#(
    parameter int ACC_W  = ACC_W_DEF,
    parameter int SAT_W  = SAT_W_DEF,
    parameter int MAX_SH = MAX_SH_DEF,
    parameter int CNT_W  = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] acc_in,
    input  logic             shl_sel,
    input  logic [CNT_W-1:0] shift_cnt,
    input  logic             sat_en,
    output logic [ACC_W-1:0] acc_out,
    output logic             ext_upd,
    output logic             ovf_upd,
    output logic             lim_upd
);

    localparam int AMT_W = $clog2(MAX_SH + 1);
    localparam int HI_N  = ACC_W - SAT_W + 1;
    localparam logic [ACC_W-1:0] SAT_POS = {{HI_N{1'b0}}, {(SAT_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] SAT_NEG = {{HI_N{1'b1}}, {(SAT_W-1){1'b0}}};

    typedef struct packed {
        logic [ACC_W-1:0] val;
        flag_upd_t        fl;
    } stage_t;

    stage_t st_d, st_q;

    logic [AMT_W-1:0] amt;
    logic [ACC_W-1:0] left_val;
    logic             left_ovf;
    logic             left_fits;
    logic             out_fits;
    shift_dir_e       dir;

    assign dir = shift_dir_e'(shl_sel);

    accsh_count_limit #(.CNT_W(CNT_W), .MAX_SH(MAX_SH), .AMT_W(AMT_W)) u_cnt (
        .cnt_raw (shift_cnt),
        .amt     (amt)
    );

    accsh_left #(.ACC_W(ACC_W), .MAX_SH(MAX_SH), .AMT_W(AMT_W)) u_left (
        .val     (acc_in),
        .amt     (amt),
        .shifted (left_val),
        .ovf     (left_ovf)
    );

    accsh_range #(.ACC_W(ACC_W), .SAT_W(SAT_W)) u_left_rng (
        .val  (left_val),
        .fits (left_fits)
    );

    accsh_range #(.ACC_W(ACC_W), .SAT_W(SAT_W)) u_out_rng (
        .val  (st_d.val),
        .fits (out_fits)
    );

    always_comb begin
        st_d        = '0;
        st_d.val    = acc_in;
        if (amt != '0) begin
            if (dir == DIR_RIGHT) begin
                st_d.val = ACC_W'($signed(acc_in) >>> amt);
            end else begin
                st_d.val    = left_val;
                st_d.fl.ovf = left_ovf;
                if (sat_en && (left_ovf || !left_fits)) begin
                    st_d.val    = acc_in[ACC_W-1] ? SAT_NEG : SAT_POS;
                    st_d.fl.lim = 1'b1;
                end
            end
        end
        st_d.fl.ext = !out_fits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_out = st_q.val;
    assign ext_upd = st_q.fl.ext;
    assign ovf_upd = st_q.fl.ovf;
    assign lim_upd = st_q.fl.lim;

    // R2
    no_shift_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_cnt == '0) |=> (acc_out == $past(acc_in)) && !ovf_upd && !lim_upd);

    // R6
    right_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shl_sel == 1'b0) |=> !ovf_upd && !lim_upd);

    // R9
    no_sat_no_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_en == 1'b0) |=> !lim_upd);

    // R8
    clamp_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lim_upd |-> ((acc_out == SAT_POS) || (acc_out == SAT_NEG)) && !ext_upd);

    // R8
    clamp_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shl_sel && sat_en && (shift_cnt != '0) && acc_in[ACC_W-1] && !acc_in[ACC_W-2])
            |=> lim_upd && (acc_out == SAT_NEG));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (acc_out == '0) && !ext_upd && !ovf_upd && !lim_upd);

endmodule

// File: tb/accsh_top_test.sv
module accsh_top_test;

    localparam int W = 40;
    localparam logic [39:0] POS = 40'h00_7FFF_FFFF;
    localparam logic [39:0] NEG = 40'hFF_8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] acc_in = '0;
    logic        shl_sel = 1'b0;
    logic [3:0]  shift_cnt = '0;
    logic        sat_en = 1'b0;
    logic [39:0] acc_out;
    logic        ext_upd, ovf_upd, lim_upd;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    accsh_top uut (
        .clk(clk), .rst_n(rst_n), .acc_in(acc_in), .shl_sel(shl_sel),
        .shift_cnt(shift_cnt), .sat_en(sat_en), .acc_out(acc_out),
        .ext_upd(ext_upd), .ovf_upd(ovf_upd), .lim_upd(lim_upd)
    );

    function automatic logic [42:0] model(logic [39:0] a, bit left, int cnt, bit sat);
        logic [39:0] v;
        bit ovf, lim, ext;
        int n;
        n = (cnt > 8) ? 8 : cnt;
        v = a; ovf = 0; lim = 0;
        if (n != 0 && !left) begin
            for (int i = 0; i < n; i++) v = {v[39], v[39:1]};
        end else if (n != 0) begin
            for (int i = 0; i < n; i++) begin
                if (v[39] != a[39]) ovf = 1;
                v = {v[38:0], 1'b0};
                if (v[39] != a[39]) ovf = 1;
            end
            if (sat && (ovf || !(v[39:31] == 9'h000 || v[39:31] == 9'h1FF))) begin
                v = a[39] ? NEG : POS;
                lim = 1;
            end
        end
        ext = !(v[39:31] == 9'h000 || v[39:31] == 9'h1FF);
        return {v, ext, ovf, lim};
    endfunction

    task automatic check(string req, logic [42:0] got, logic [42:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got out=%h ext=%0b ovf=%0b lim=%0b expected out=%h ext=%0b ovf=%0b lim=%0b",
                     req, got[42:3], got[2], got[1], got[0], exp[42:3], exp[2], exp[1], exp[0]);
        end
    endtask

    task automatic apply(logic [39:0] a, bit left, int cnt, bit sat, string req);
        logic [42:0] exp;
        logic [42:0] e8;
        @(negedge clk);
        acc_in = a; shl_sel = left; shift_cnt = 4'(cnt); sat_en = sat;
        exp = model(a, left, cnt, sat);
        @(negedge clk);
        // R11: sampled one cycle after the inputs were captured
        check(req, {acc_out, ext_upd, ovf_upd, lim_upd}, exp);
        // R10: extension update follows the output range
        check("R10", {39'd0, ext_upd, 3'd0},
              {39'd0, !(acc_out[39:31] == 9'h000 || acc_out[39:31] == 9'h1FF), 3'd0});
        if (cnt > 8) begin
            e8 = model(a, left, 8, sat);
            check("R3", {acc_out, ext_upd, ovf_upd, lim_upd}, e8);
        end
    endtask

    function automatic string tag(bit left, int cnt, bit sat);
        if (cnt == 0) return "R2";
        if (cnt > 8) return "R3";
        if (!left) return "R4/R6";
        if (sat) return "R8";
        return "R5/R7/R9";
    endfunction

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [39:0] a;
        bit l, s;
        int c;
        void'($urandom(32'h5EED_1234));
        acc_in = 40'hFF_FFFF_FFFF; shift_cnt = 4'd3; shl_sel = 1'b1; sat_en = 1'b1;
        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset
        check("R1", {acc_out, ext_upd, ovf_upd, lim_upd}, 43'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // directed corners
        apply(40'h12_3456_789A, 1, 0, 1, "R2");
        apply(40'h80_0000_0001, 0, 8, 0, "R4");
        apply(40'h80_0000_0001, 0, 15, 0, "R3");
        apply(40'h00_0000_0003, 1, 4, 0, "R5");
        apply(40'h00_4000_0000, 1, 1, 0, "R9");
        apply(40'h00_4000_0000, 1, 1, 1, "R8");
        apply(40'h40_0000_0000, 1, 1, 0, "R7");
        apply(40'h40_0000_0000, 1, 1, 1, "R8");
        apply(40'hC0_0000_0000, 1, 1, 0, "R7");
        apply(40'hFF_C000_0000, 1, 2, 1, "R8");
        apply(40'h01_0000_0000, 1, 8, 0, "R7");
        apply(40'h00_8000_0000, 1, 8, 0, "R7");
        apply(40'hFF_FFFF_FFFF, 1, 12, 1, "R3");
        apply(40'h7F_FFFF_FFFF, 0, 1, 1, "R6");

        for (int i = 0; i < 3000; i++) begin
            a = {8'($urandom), $urandom};
            case ($urandom % 4)
                0: a[39:30] = '0;
                1: a[39:30] = '1;
                default: ;
            endcase
            l = 1'($urandom);
            s = 1'($urandom);
            c = int'($urandom % 16);
            apply(a, l, c, s, tag(l, c, s));
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule